// File: doc/BRIEF.md
# Controller Command Packet Dispatcher

This block sits behind the host link of a small system controller. The host sends a complete packet as a byte stream. The first byte is the packet class and the second is a command code; any bytes after that are arguments. Only controller-class packets (class 1) are handled here. Packets of the peripheral-bus class (class 0), or of any other class, are left to the bus logic and get no reply from this block. For a controller packet the block looks up the command and checks that the number of arguments is exactly the number the command takes. It then either carries out the command and returns an acknowledge, or returns a coded error packet.

The block holds the controller state that the commands touch: a 32-bit seconds counter that a one-second tick advances, an autopoll enable, a poll period in milliseconds and a 16-bit device poll mask. These values are brought out as ports for the polling logic. Power-down and system-reset commands produce a one-cycle request pulse. When autopoll is on, result packets from the poller are passed to the host behind a two-byte header. When autopoll is off, those bytes are taken in and dropped.

Replies leave on a valid/ready byte stream that marks the last byte. A new host packet is not taken in until the reply to the previous one has been fully drained.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset the reply stream is idle, in_ready is 1, autopoll is off, the poll period is 20, the poll mask is 0xFFFF and the seconds count is 0.
- R2: A command that succeeds replies with 1, 0, the command code, then any result bytes. out_last is high on the final byte only.
- R3: When a known command arrives with more or fewer argument bytes than it takes, the reply is 2, 5, 1, command code, and no state changes. This includes packets longer than the argument store.
- R4: A command code outside the supported set replies with 2, 2, 1, command code.
- R5: Command 0x03 takes no arguments. Its reply carries the current seconds count as four bytes, most significant first.
- R6: Command 0x09 takes four bytes, most significant first, and loads the seconds count. Each cycle with sec_tick high adds one to the count.
- R7: Command 0x01 takes one byte. A nonzero byte turns autopoll on and a zero byte turns it off.
- R8: Command 0x14 takes one byte and sets the poll period in milliseconds. A zero byte is answered as bad arguments (2, 5, 1, 0x14) and the period stays unchanged, so it is never 0.
- R9: Command 0x19 takes two bytes, high byte first, and these form the poll mask.
- R10: Command 0x0A (no arguments) gives a one-cycle pwrdn_req pulse and command 0x11 (no arguments) gives a one-cycle sysrst_req pulse. A rejected packet gives neither pulse.
- R11: Commands 0x13 and 0x21 each take one byte. They are acknowledged and change no state.
- R12: A packet whose class byte is not 1, or one that ends before its command byte, gets no reply and changes no state.
- R13: in_ready stays low from the acceptance of a packet's last byte until the last reply byte has been taken. A stalled reply byte holds its value.
- R14: With autopoll on, a poll packet goes out as 0, 0x40, then its bytes, with out_last taken from poll_last. With autopoll off, poll bytes are consumed and nothing is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-second tick enable |
| in_valid | input | 1 | Host packet byte valid |
| in_ready | output | 1 | Host packet byte accepted |
| in_data | input | 8 | Host packet byte |
| in_last | input | 1 | Final byte of the host packet |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte taken |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| poll_valid | input | 1 | Poll result byte valid |
| poll_ready | output | 1 | Poll result byte accepted |
| poll_data | input | 8 | Poll result byte |
| poll_last | input | 1 | Final poll result byte |
| autopoll_en | output | 1 | Autopoll enable |
| poll_period_ms | output | 8 | Poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| seconds | output | 32 | Seconds count |
| pwrdn_req | output | 1 | Power-down request pulse |
| sysrst_req | output | 1 | System-reset request pulse |

## Verification
The bench sends argument counts one above and one below each command's count, and a packet longer than the argument store. A checker that ignored the count would acknowledge these and change state, and a counter that wrapped would mistake the long packet for a valid one. A zero poll period, empty and foreign-class packets, and rejected power commands check that errors leave the period, the mask and the request pulses untouched. Random backpressure on the reply and a poll packet with autopoll both on and off show whether a byte changes while stalled, whether the host side accepts bytes while a reply is pending, and whether the poll header is missing or dropped poll bytes leak out.

// File: rtl/cmdd_pkg.sv
package cmdd_pkg;

   localparam logic [7:0] CLS_CTRL    = 8'h01;
   localparam logic [7:0] CLS_ERR     = 8'h02;
   localparam logic [7:0] ERR_UNKNOWN = 8'h02;
   localparam logic [7:0] ERR_BADARG  = 8'h05;
   localparam logic [7:0] POLL_MARK   = 8'h40;

   localparam logic [7:0] OP_AUTOPOLL = 8'h01;
   localparam logic [7:0] OP_TIME_RD  = 8'h03;
   localparam logic [7:0] OP_TIME_WR  = 8'h09;
   localparam logic [7:0] OP_PWRDN    = 8'h0A;
   localparam logic [7:0] OP_SYSRST   = 8'h11;
   localparam logic [7:0] OP_SRVFLAG  = 8'h13;
   localparam logic [7:0] OP_PERIOD   = 8'h14;
   localparam logic [7:0] OP_MASK     = 8'h19;
   localparam logic [7:0] OP_PWRMSG   = 8'h21;

   // longest reply: three header bytes plus four count bytes
   localparam int REP_MAX = 7;
   localparam int REP_LW  = $clog2(REP_MAX + 1);

   typedef struct packed {
      logic        sec_we;
      logic [31:0] sec_val;
      logic        ap_we;
      logic        ap_val;
      logic        per_we;
      logic [7:0]  per_val;
      logic        mask_we;
      logic [15:0] mask_val;
      logic        pwrdn;
      logic        sysrst;
   } upd_t;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_HOST,
      TX_HDR0,
      TX_HDR1,
      TX_BODY
   } tx_st_t;

endpackage

// File: rtl/cmdd_rx.sv
module cmdd_rx #(
   parameter int ARG_DEPTH = 6,
   parameter int CNT_W     = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   accept,
   input  logic [7:0]             in_data,
   input  logic                   in_last,
   input  logic                   clear,
   output logic                   done,
   output logic [7:0]             pkt_cls,
   output logic [7:0]             pkt_cmd,
   output logic [CNT_W-1:0]       pkt_len,
   output logic [ARG_DEPTH*8-1:0] pkt_args
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] pos_inc;

   assign pos_inc = (pos_q == CNT_MAX) ? pos_q : pos_q + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         done    <= 1'b0;
         pkt_len <= '0;
         pkt_cls <= '0;
         pkt_cmd <= '0;
      end else begin
         if (clear) done <= 1'b0;
         if (accept) begin
            if (pos_q == CNT_W'(0)) pkt_cls <= in_data;
            if (pos_q == CNT_W'(1)) pkt_cmd <= in_data;
            if (in_last) begin
               pos_q   <= '0;
               done    <= 1'b1;
               pkt_len <= pos_inc;
            end else begin
               pos_q   <= pos_inc;
            end
         end
      end
   end

   for (genvar g = 0; g < ARG_DEPTH; g++) begin : g_arg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pkt_args[g*8 +: 8] <= '0;
         end else if (accept && pos_q == CNT_W'(g + 2)) begin
            pkt_args[g*8 +: 8] <= in_data;
         end
      end
   end

endmodule

// File: rtl/cmdd_exec.sv
module cmdd_exec
   import cmdd_pkg::*;
#(
   parameter int ARG_DEPTH = 6,
   parameter int CNT_W     = 5
) (
   input  logic [7:0]             pkt_cls,
   input  logic [7:0]             pkt_cmd,
   input  logic [CNT_W-1:0]       pkt_len,
   input  logic [ARG_DEPTH*8-1:0] pkt_args,
   input  logic [31:0]            sec_now,
   output logic [REP_LW-1:0]      rep_len,
   output logic [REP_MAX*8-1:0]   rep_bytes,
   output upd_t                   upd
);

   logic [CNT_W-1:0] nargs;
   logic [CNT_W-1:0] need;
   logic             known;
   logic [7:0]       a0, a1, a2, a3;
   logic [7:0]       rb [REP_MAX];

   assign nargs = pkt_len - CNT_W'(2);
   assign a0 = pkt_args[7:0];
   assign a1 = pkt_args[15:8];
   assign a2 = pkt_args[23:16];
   assign a3 = pkt_args[31:24];

   always_comb begin
      known = 1'b1;
      need  = '0;
      case (pkt_cmd)
         OP_AUTOPOLL, OP_SRVFLAG, OP_PWRMSG, OP_PERIOD: need = CNT_W'(1);
         OP_TIME_RD, OP_PWRDN, OP_SYSRST:               need = CNT_W'(0);
         OP_TIME_WR:                                    need = CNT_W'(4);
         OP_MASK:                                       need = CNT_W'(2);
         default:                                       known = 1'b0;
      endcase
   end

   always_comb begin
      upd     = '0;
      rep_len = '0;
      for (int i = 0; i < REP_MAX; i++) rb[i] = 8'h00;
      if (pkt_cls == CLS_CTRL && pkt_len >= CNT_W'(2)) begin
         if (!known) begin
            rb[0] = CLS_ERR; rb[1] = ERR_UNKNOWN; rb[2] = CLS_CTRL; rb[3] = pkt_cmd;
            rep_len = REP_LW'(4);
         end else if (nargs != need || (pkt_cmd == OP_PERIOD && a0 == 8'h00)) begin
            rb[0] = CLS_ERR; rb[1] = ERR_BADARG; rb[2] = CLS_CTRL; rb[3] = pkt_cmd;
            rep_len = REP_LW'(4);
         end else begin
            rb[0] = CLS_CTRL; rb[1] = 8'h00; rb[2] = pkt_cmd;
            rep_len = REP_LW'(3);
            case (pkt_cmd)
               OP_TIME_RD: begin
                  rb[3] = sec_now[31:24]; rb[4] = sec_now[23:16];
                  rb[5] = sec_now[15:8];  rb[6] = sec_now[7:0];
                  rep_len = REP_LW'(7);
               end
               OP_TIME_WR: begin
                  upd.sec_we  = 1'b1;
                  upd.sec_val = {a0, a1, a2, a3};
               end
               OP_AUTOPOLL: begin
                  upd.ap_we  = 1'b1;
                  upd.ap_val = (a0 != 8'h00);
               end
               OP_PERIOD: begin
                  upd.per_we  = 1'b1;
                  upd.per_val = a0;
               end
               OP_MASK: begin
                  upd.mask_we  = 1'b1;
                  upd.mask_val = {a0, a1};
               end
               OP_PWRDN:  upd.pwrdn  = 1'b1;
               OP_SYSRST: upd.sysrst = 1'b1;
               default: ;
            endcase
         end
      end
   end

   for (genvar g = 0; g < REP_MAX; g++) begin : g_pack
      assign rep_bytes[g*8 +: 8] = rb[g];
   end

endmodule

// File: rtl/cmdd_tx.sv
module cmdd_tx
   import cmdd_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [REP_LW-1:0]    load_len,
   input  logic [REP_MAX*8-1:0] load_bytes,
   input  logic                 ap_en,
   input  logic                 poll_valid,
   output logic                 poll_ready,
   input  logic [7:0]           poll_data,
   input  logic                 poll_last,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [7:0]           out_data,
   output logic                 out_last,
   output logic                 tx_idle
);

   tx_st_t            st_q;
   logic [7:0]        buf_q [REP_MAX];
   logic [REP_LW-1:0] idx_q;
   logic [REP_LW-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TX_IDLE;
         idx_q <= '0;
         len_q <= '0;
         for (int i = 0; i < REP_MAX; i++) buf_q[i] <= 8'h00;
      end else begin
         case (st_q)
            TX_IDLE: begin
               if (load) begin
                  for (int i = 0; i < REP_MAX; i++) buf_q[i] <= load_bytes[i*8 +: 8];
                  idx_q <= '0;
                  len_q <= load_len;
                  if (load_len != '0) st_q <= TX_HOST;
               end else if (poll_valid && ap_en) begin
                  st_q <= TX_HDR0;
               end
            end
            TX_HOST: begin
               if (out_ready) begin
                  if (idx_q == len_q - REP_LW'(1)) st_q <= TX_IDLE;
                  else idx_q <= idx_q + REP_LW'(1);
               end
            end
            TX_HDR0: if (out_ready) st_q <= TX_HDR1;
            TX_HDR1: if (out_ready) st_q <= TX_BODY;
            TX_BODY: if (poll_valid && out_ready && poll_last) st_q <= TX_IDLE;
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   always_comb begin
      out_valid  = 1'b0;
      out_data   = 8'h00;
      out_last   = 1'b0;
      poll_ready = 1'b0;
      case (st_q)
         TX_IDLE: poll_ready = !ap_en && !load;
         TX_HOST: begin
            out_valid = 1'b1;
            out_data  = buf_q[idx_q];
            out_last  = (idx_q == len_q - REP_LW'(1));
         end
         TX_HDR0: begin
            out_valid = 1'b1;
            out_data  = 8'h00;
         end
         TX_HDR1: begin
            out_valid = 1'b1;
            out_data  = POLL_MARK;
         end
         TX_BODY: begin
            out_valid  = poll_valid;
            out_data   = poll_data;
            out_last   = poll_last;
            poll_ready = out_ready;
         end
         default: ;
      endcase
   end

   assign tx_idle = (st_q == TX_IDLE);

endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
   import cmdd_pkg::*;
#(
   parameter int          ARG_DEPTH    = 6,
   parameter logic [7:0]  RESET_PERIOD = 8'd20,
   parameter logic [15:0] RESET_MASK   = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sec_tick,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [7:0]  in_data,
   input  logic        in_last,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [7:0]  out_data,
   output logic        out_last,
   input  logic        poll_valid,
   output logic        poll_ready,
   input  logic [7:0]  poll_data,
   input  logic        poll_last,
   output logic        autopoll_en,
   output logic [7:0]  poll_period_ms,
   output logic [15:0] poll_mask,
   output logic [31:0] seconds,
   output logic        pwrdn_req,
   output logic        sysrst_req
);

   // one spare bit so an overlong packet saturates well above any legal length
   localparam int CNT_W = $clog2(ARG_DEPTH + 3) + 1;

   if (ARG_DEPTH < 4) begin : g_bad_depth
      $error("ARG_DEPTH must hold the longest argument list (4)");
   end
   if (RESET_PERIOD == 8'd0) begin : g_bad_period
      $error("RESET_PERIOD must be nonzero");
   end

   logic                   done;
   logic                   load;
   logic                   tx_idle;
   logic [7:0]             pkt_cls;
   logic [7:0]             pkt_cmd;
   logic [CNT_W-1:0]       pkt_len;
   logic [ARG_DEPTH*8-1:0] pkt_args;
   logic [REP_LW-1:0]      rep_len;
   logic [REP_MAX*8-1:0]   rep_bytes;
   upd_t                   upd;

   assign load     = done && tx_idle;
   assign in_ready = tx_idle && !done;

   cmdd_rx #(.ARG_DEPTH(ARG_DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (in_valid && in_ready),
      .in_data  (in_data),
      .in_last  (in_last),
      .clear    (load),
      .done     (done),
      .pkt_cls  (pkt_cls),
      .pkt_cmd  (pkt_cmd),
      .pkt_len  (pkt_len),
      .pkt_args (pkt_args)
   );

   cmdd_exec #(.ARG_DEPTH(ARG_DEPTH), .CNT_W(CNT_W)) u_exec (
      .pkt_cls   (pkt_cls),
      .pkt_cmd   (pkt_cmd),
      .pkt_len   (pkt_len),
      .pkt_args  (pkt_args),
      .sec_now   (seconds),
      .rep_len   (rep_len),
      .rep_bytes (rep_bytes),
      .upd       (upd)
   );

   cmdd_tx u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_len   (rep_len),
      .load_bytes (rep_bytes),
      .ap_en      (autopoll_en),
      .poll_valid (poll_valid),
      .poll_ready (poll_ready),
      .poll_data  (poll_data),
      .poll_last  (poll_last),
      .out_valid  (out_valid),
      .out_ready  (out_ready),
      .out_data   (out_data),
      .out_last   (out_last),
      .tx_idle    (tx_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seconds <= '0;
      end else if (load && upd.sec_we) begin
         seconds <= upd.sec_val;
      end else if (sec_tick) begin
         seconds <= seconds + 32'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autopoll_en    <= 1'b0;
         poll_period_ms <= RESET_PERIOD;
         poll_mask      <= RESET_MASK;
         pwrdn_req      <= 1'b0;
         sysrst_req     <= 1'b0;
      end else begin
         pwrdn_req  <= load && upd.pwrdn;
         sysrst_req <= load && upd.sysrst;
         if (load && upd.ap_we)   autopoll_en    <= upd.ap_val;
         if (load && upd.per_we)  poll_period_ms <= upd.per_val;
         if (load && upd.mask_we) poll_mask      <= upd.mask_val;
      end
   end

endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sec_tick,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [7:0]  out_data,
   input logic        out_last,
   input logic [7:0]  poll_period_ms,
   input logic [31:0] seconds,
   input logic        pwrdn_req,
   input logic        sysrst_req
);

   // R13: no host byte is taken while a reply is on the wire
   p_no_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R13: a stalled reply byte holds
   p_hold_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R8: the period can never be zero
   p_period_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      poll_period_ms != 8'd0);

   // R10: request pulses last one cycle
   p_pwrdn_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn_req |=> !pwrdn_req);
   p_sysrst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_req |=> !sysrst_req);
   p_req_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwrdn_req && sysrst_req));

   // R6: with no packet pending, only the tick moves the count
   p_tick_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && sec_tick) |=> (seconds == $past(seconds) + 32'd1));
   p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !sec_tick) |=> $stable(seconds));

endmodule

bind cmd_dispatch cmd_dispatch_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sec_tick       (sec_tick),
   .in_ready       (in_ready),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_data       (out_data),
   .out_last       (out_last),
   .poll_period_ms (poll_period_ms),
   .seconds        (seconds),
   .pwrdn_req      (pwrdn_req),
   .sysrst_req     (sysrst_req)
);

// File: tb/cmd_dispatch_bench.sv
module cmd_dispatch_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = 8'h00;
   logic        in_last = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        out_last;
   logic        poll_valid = 1'b0;
   logic        poll_ready;
   logic [7:0]  poll_data = 8'h00;
   logic        poll_last = 1'b0;
   logic        autopoll_en;
   logic [7:0]  poll_period_ms;
   logic [15:0] poll_mask;
   logic [31:0] seconds;
   logic        pwrdn_req;
   logic        sysrst_req;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmd_dispatch u_cmd_dispatch (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
      .poll_valid(poll_valid), .poll_ready(poll_ready), .poll_data(poll_data), .poll_last(poll_last),
      .autopoll_en(autopoll_en), .poll_period_ms(poll_period_ms), .poll_mask(poll_mask),
      .seconds(seconds), .pwrdn_req(pwrdn_req), .sysrst_req(sysrst_req)
   );

   int n_chk = 0;
   int n_fail = 0;

   // model of the controller state
   logic [31:0] m_sec  = 32'd0;
   logic        m_ap   = 1'b0;
   logic [7:0]  m_per  = 8'd20;
   logic [15:0] m_mask = 16'hFFFF;
   int exp_pd = 0, exp_rs = 0;
   int got_pd = 0, got_rs = 0;
   int overlap_err = 0, stall_err = 0;
   logic        stall_seen = 1'b0;
   logic [7:0]  stall_data;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   // monitors: pulses, R13 overlap and stall stability
   always @(negedge clk) begin
      #3;
      if (rst_n) begin
         if (pwrdn_req)  got_pd++;
         if (sysrst_req) got_rs++;
         if (out_valid && in_ready) overlap_err++;
         if (stall_seen && (!out_valid || out_data != stall_data)) stall_err++;
         stall_seen = out_valid && !out_ready;
         stall_data = out_data;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   // expected reply from the requirements; updates the model state
   task automatic model_pkt(input logic [7:0] pk[16], input int n,
                            output logic [7:0] e[16], output int en);
      int need;
      en = 0;
      for (int i = 0; i < 16; i++) e[i] = 8'h00;
      if (n < 2 || pk[0] != 8'h01) return;                      // R12
      case (pk[1])
         8'h01, 8'h13, 8'h14, 8'h21: need = 1;
         8'h03, 8'h0A, 8'h11:        need = 0;
         8'h09:                      need = 4;
         8'h19:                      need = 2;
         default:                    need = -1;
      endcase
      if (need < 0) begin                                         // R4
         e[0] = 8'h02; e[1] = 8'h02; e[2] = 8'h01; e[3] = pk[1]; en = 4;
      end else if ((n - 2) != need || (pk[1] == 8'h14 && pk[2] == 8'h00)) begin // R3 R8
         e[0] = 8'h02; e[1] = 8'h05; e[2] = 8'h01; e[3] = pk[1]; en = 4;
      end else begin                                              // R2
         e[0] = 8'h01; e[1] = 8'h00; e[2] = pk[1]; en = 3;
         case (pk[1])
            8'h03: begin
               e[3] = m_sec[31:24]; e[4] = m_sec[23:16];
               e[5] = m_sec[15:8];  e[6] = m_sec[7:0]; en = 7;
            end
            8'h09: m_sec  = {pk[2], pk[3], pk[4], pk[5]};
            8'h01: m_ap   = (pk[2] != 8'h00);
            8'h14: m_per  = pk[2];
            8'h19: m_mask = {pk[2], pk[3]};
            8'h0A: exp_pd++;
            8'h11: exp_rs++;
            default: ;
         endcase
      end
   endtask

   task automatic send_pkt(input logic [7:0] pk[16], input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = pk[i]; in_last = (i == n - 1);
         #1;
         while (!in_ready) begin @(negedge clk); #1; end
         @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic get_reply(output logic [7:0] r[16], output int rn, input bit rnd);
      int idle;
      rn = 0; idle = 0;
      for (int i = 0; i < 16; i++) r[i] = 8'h00;
      while (idle < 30) begin
         @(negedge clk);
         out_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
         #1;
         if (out_valid && out_ready) begin
            if (rn < 16) r[rn] = out_data;
            rn++; idle = 0;
            if (out_last) begin
               @(posedge clk);
               #1 out_ready = 1'b0;
               return;
            end
         end else begin
            idle++;
         end
      end
      out_ready = 1'b0;
   endtask

   task automatic run_pkt(input logic [7:0] pk[16], input int n, input string req, input bit rnd);
      logic [7:0] e[16];
      logic [7:0] r[16];
      int en, rn, bad;
      model_pkt(pk, n, e, en);
      send_pkt(pk, n);
      if (en > 0) begin
         chk(!in_ready, "R13", "in_ready while reply pending", longint'(in_ready), 0);
      end
      get_reply(r, rn, rnd);
      bad = -1;
      for (int i = 0; i < en && i < rn; i++) if (bad < 0 && r[i] != e[i]) bad = i;
      if (rn != en) chk(1'b0, req, "reply length", rn, en);
      else if (bad >= 0) chk(1'b0, req, $sformatf("reply byte %0d", bad), r[bad], e[bad]);
      else chk(1'b1, req, "reply", 0, 0);
   endtask

   task automatic drive_poll(input logic [7:0] d[8], input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         poll_valid = 1'b1; poll_data = d[i]; poll_last = (i == n - 1);
         #2;
         while (!poll_ready) begin @(negedge clk); #2; end
         @(posedge clk);
      end
      @(negedge clk);
      poll_valid = 1'b0; poll_last = 1'b0;
   endtask

   task automatic tick(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk); sec_tick = 1'b1;
         @(negedge clk); sec_tick = 1'b0;
         m_sec = m_sec + 32'd1;
      end
   endtask

   function automatic void mk(output logic [7:0] pk[16], input logic [7:0] b0, b1, b2, b3, b4, b5);
      for (int i = 0; i < 16; i++) pk[i] = 8'h00;
      pk[0] = b0; pk[1] = b1; pk[2] = b2; pk[3] = b3; pk[4] = b4; pk[5] = b5;
   endfunction

   initial begin
      logic [7:0] pk[16];
      logic [7:0] pd[8];
      logic [7:0] r[16];
      int rn;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle handshake", {in_ready, out_valid}, 2'b10);
      chk(autopoll_en == 1'b0, "R1", "autopoll", autopoll_en, 0);
      chk(poll_period_ms == 8'd20, "R1", "period", poll_period_ms, 20);
      chk(poll_mask == 16'hFFFF, "R1", "mask", poll_mask, 16'hFFFF);
      chk(seconds == 32'd0, "R1", "seconds", seconds, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6 ticks then R5 read
      tick(3);
      #1 chk(seconds == 32'd3, "R6", "seconds after ticks", seconds, 3);
      mk(pk, 8'h01, 8'h03, 0, 0, 0, 0); run_pkt(pk, 2, "R5", 1'b1);
      mk(pk, 8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78); run_pkt(pk, 6, "R6", 1'b1);
      #1 chk(seconds == 32'h12345678, "R6", "seconds loaded", seconds, 32'h12345678);
      mk(pk, 8'h01, 8'h03, 0, 0, 0, 0); run_pkt(pk, 2, "R5", 1'b0);

      // R7 autopoll
      mk(pk, 8'h01, 8'h01, 8'h05, 0, 0, 0); run_pkt(pk, 3, "R7", 1'b1);
      chk(autopoll_en == 1'b1, "R7", "autopoll on", autopoll_en, 1);
      mk(pk, 8'h01, 8'h01, 8'h00, 0, 0, 0); run_pkt(pk, 3, "R7", 1'b1);
      chk(autopoll_en == 1'b0, "R7", "autopoll off", autopoll_en, 0);

      // R8 period
      mk(pk, 8'h01, 8'h14, 8'h00, 0, 0, 0); run_pkt(pk, 3, "R8", 1'b1);
      chk(poll_period_ms == 8'd20, "R8", "period after zero", poll_period_ms, 20);
      mk(pk, 8'h01, 8'h14, 8'd50, 0, 0, 0); run_pkt(pk, 3, "R8", 1'b1);
      chk(poll_period_ms == 8'd50, "R8", "period set", poll_period_ms, 50);

      // R9 mask
      mk(pk, 8'h01, 8'h19, 8'hAB, 8'hCD, 0, 0); run_pkt(pk, 4, "R9", 1'b1);
      chk(poll_mask == 16'hABCD, "R9", "mask", poll_mask, 16'hABCD);

      // R3 wrong counts, one over, one under, overlong
      mk(pk, 8'h01, 8'h03, 8'h01, 0, 0, 0); run_pkt(pk, 3, "R3", 1'b1);
      mk(pk, 8'h01, 8'h19, 8'h11, 8'h22, 8'h33, 0); run_pkt(pk, 5, "R3", 1'b1);
      mk(pk, 8'h01, 8'h09, 8'h01, 8'h02, 8'h03, 0); run_pkt(pk, 5, "R3", 1'b1);
      mk(pk, 8'h01, 8'h09, 8'h01, 8'h02, 8'h03, 8'h04);
      for (int i = 6; i < 16; i++) pk[i] = 8'h99;
      run_pkt(pk, 16, "R3", 1'b1);
      chk(seconds == m_sec && poll_mask == 16'hABCD, "R3", "state kept", seconds, m_sec);

      // R4 unknown
      mk(pk, 8'h01, 8'h07, 0, 0, 0, 0); run_pkt(pk, 2, "R4", 1'b1);
      mk(pk, 8'h01, 8'hFF, 8'h01, 0, 0, 0); run_pkt(pk, 3, "R4", 1'b1);

      // R10 pulses
      mk(pk, 8'h01, 8'h0A, 0, 0, 0, 0); run_pkt(pk, 2, "R10", 1'b1);
      mk(pk, 8'h01, 8'h11, 8'h00, 0, 0, 0); run_pkt(pk, 3, "R10", 1'b1);
      mk(pk, 8'h01, 8'h11, 0, 0, 0, 0); run_pkt(pk, 2, "R10", 1'b1);
      chk(got_pd == 1 && got_rs == 1, "R10", "pulse counts", {got_pd[7:0], got_rs[7:0]}, 16'h0101);

      // R11 flag and message acks
      mk(pk, 8'h01, 8'h13, 8'h07, 0, 0, 0); run_pkt(pk, 3, "R11", 1'b1);
      mk(pk, 8'h01, 8'h21, 8'h01, 0, 0, 0); run_pkt(pk, 3, "R11", 1'b1);
      chk(autopoll_en == 1'b0 && poll_period_ms == 8'd50 && poll_mask == 16'hABCD,
          "R11", "state unchanged", poll_period_ms, 50);

      // R12 foreign class and truncated packets
      mk(pk, 8'h00, 8'h19, 8'h00, 8'h00, 0, 0); run_pkt(pk, 4, "R12", 1'b1);
      mk(pk, 8'h01, 0, 0, 0, 0, 0); run_pkt(pk, 1, "R12", 1'b1);
      chk(poll_mask == 16'hABCD, "R12", "mask unchanged", poll_mask, 16'hABCD);

      // R14 poll with autopoll off: consumed, nothing sent
      for (int i = 0; i < 8; i++) pd[i] = 8'hA0 + 8'(i);
      fork
         drive_poll(pd, 2);
         get_reply(r, rn, 1'b0);
      join
      chk(rn == 0, "R14", "output with autopoll off", rn, 0);
      // autopoll on
      mk(pk, 8'h01, 8'h01, 8'h01, 0, 0, 0); run_pkt(pk, 3, "R7", 1'b1);
      fork
         drive_poll(pd, 3);
         get_reply(r, rn, 1'b1);
      join
      chk(rn == 5 && r[0] == 8'h00 && r[1] == 8'h40 && r[2] == 8'hA0 && r[3] == 8'hA1 && r[4] == 8'hA2,
          "R14", "wrapped poll packet", {r[0], r[1], r[2], r[3], r[4]}, 40'h0040A0A1A2);
      mk(pk, 8'h01, 8'h01, 8'h00, 0, 0, 0); run_pkt(pk, 3, "R7", 1'b1);

      // random mix
      for (int k = 0; k < 200; k++) begin
         int n;
         logic [7:0] ops[10];
         ops = '{8'h01, 8'h03, 8'h09, 8'h0A, 8'h11, 8'h13, 8'h14, 8'h19, 8'h21, 8'h00};
         for (int i = 0; i < 16; i++) pk[i] = 8'($urandom);
         pk[0] = ($urandom % 10 == 0) ? 8'h00 : 8'h01;
         pk[1] = ops[$urandom % 10];
         if (pk[1] == 8'h00) pk[1] = 8'($urandom);
         if (pk[1] == 8'h14 && $urandom % 4 == 0) pk[2] = 8'h00;
         case (pk[1])
            8'h01, 8'h13, 8'h14, 8'h21: n = 3;
            8'h09: n = 6;
            8'h19: n = 4;
            default: n = 2;
         endcase
         if ($urandom % 4 == 0) n = 2 + int'($urandom % 8);
         run_pkt(pk, n, "R2", 1'b1);
      end
      chk(seconds == m_sec, "R6", "random seconds", seconds, m_sec);
      chk(poll_period_ms == m_per && poll_mask == m_mask && autopoll_en == m_ap,
          "R9", "random state", poll_mask, m_mask);
      chk(got_pd == exp_pd && got_rs == exp_rs, "R10", "random pulses", got_pd, exp_pd);
      chk(overlap_err == 0, "R13", "accept during reply", overlap_err, 0);
      chk(stall_err == 0, "R13", "stalled byte changed", stall_err, 0);
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule